// File: doc/BRIEF.md
# Interrupt Status, Mask and Coalescing Controller

This block gathers event pulses from the receive and transmit engines and from the packet buffers of a network interface. It turns them into one level-sensitive interrupt line toward the CPU. Each event sets a sticky bit in a status register. Software clears those bits by writing ones. A mask register selects which status bits count, and a global enable gates delivery. The result of status AND mask is called the effective set.

Delivery can be held back by a programmable number of clock cycles so that bursts of events raise a single interrupt. Events in the immediate class skip that wait. A later event never pushes back a delivery that is already scheduled. The two watermark sources, receive-high and transmit-low, are qualified by hysteresis flags. The flags are re-armed by the buffer-empty and buffer-full level inputs. Software writes to the mask or to the enable take effect at once. The packet buffers, and the decision about when a watermark event is posted, stay with the requester.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After reset the status register is zero, the global enable is off, the interrupt line is low, and the mask enables only bit 0 (receive copy done), bit 2 (receive high watermark) and bit 5 (transmit low watermark), so maskOut = 0x25.
- R2: A post ORs postReq into status at the next clock edge. A status-clear write removes the bits written as ones. When a bit is posted and cleared in the same cycle, it ends up set.
- R3: Bit 7 is reserved. A post or a clear that carries it is dropped as a whole and leaves status unchanged. reqErr is high in the cycle after such a request.
- R4: irqOut is high only while status AND mask is nonzero. It falls at the edge where a clear or mask change makes that value zero.
- R5: When no qualified source of a post belongs to the immediate class, irqOut rises exactly dlyCycles clock edges after the edge that accepted the post. A dlyCycles value of 0 delivers at that same edge.
- R6: Bit 6 (transmit buffer full) belongs to the immediate class. Posting it raises irqOut at the accepting edge, even while a delayed delivery is still waiting.
- R7: A delayed post whose delivery time would fall after an already scheduled delivery merges into it. The earlier delivery time is kept.
- R8: A receive-high post (bit 2) schedules delivery only when the receive hysteresis flag is armed, and doing so disarms the flag. rxBufEmpty high re-arms it. The flag is armed at reset.
- R9: A transmit-low post (bit 5) schedules delivery only when the transmit hysteresis flag is armed, and doing so disarms the flag. txBufFull high re-arms it. The flag is armed at reset.
- R10: A mask write that changes the mask while the enable is on and leaves status AND mask nonzero raises irqOut at that edge.
- R11: While the global enable is off, posts set status but never raise irqOut. Turning the enable on while status AND mask is nonzero raises irqOut at that edge.
- R12: A scheduled delivery is dropped when the enable is turned off or when status AND mask becomes zero before it expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postReq | input | NSRC | Event pulses, one bit per source |
| clrWr | input | 1 | Status write-one-to-clear strobe |
| clrData | input | NSRC | Bits to clear |
| maskWr | input | 1 | Mask write strobe |
| maskData | input | NSRC | New mask value |
| enWr | input | 1 | Global enable write strobe |
| enData | input | 1 | New global enable value |
| dlyCycles | input | DLY_W | Coalescing delay in clock cycles |
| rxBufEmpty | input | 1 | Receive buffer empty level, re-arms bit 2 |
| txBufFull | input | 1 | Transmit buffer full level, re-arms bit 5 |
| statusOut | output | NSRC | Status register |
| maskOut | output | NSRC | Mask register |
| enOut | output | 1 | Global enable |
| irqOut | output | 1 | Level interrupt to the CPU |
| reqErr | output | 1 | Reserved-bit request was rejected |

## Verification
A sweep posts every single source bit in turn with the mask fully open. It tells the reserved bit, the immediate class and the delayed class apart by the exact edge where the line rises, and confirms that a clear drops the line. Directed sequences repeat watermark posts with and without an intervening buffer-empty or buffer-full level, which separates armed from disarmed hysteresis. Overlapping posts with a long delay distinguish merging from rescheduling. Mask, enable and clear writes issued during a pending wait separate immediate delivery from cancellation.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Source bit positions; requesters and software rely on these.
  localparam int SRC_RX_DMA  = 0;
  localparam int SRC_RX_PKT  = 1;
  localparam int SRC_RX_HIGH = 2;
  localparam int SRC_TX_DMA  = 3;
  localparam int SRC_TX_PKT  = 4;
  localparam int SRC_TX_LOW  = 5;
  localparam int SRC_TX_FULL = 6;
  localparam int SRC_RSV     = 7;

  // Strobes from the status datapath to the delivery control.
  typedef struct packed {
    logic post;     // accepted post with a qualified source
    logic noDelay;  // qualified set holds an immediate-class source
    logic kick;     // software write asks for immediate delivery
    logic enNext;   // enable value after this edge
    logic effZero;  // status AND mask is zero after this edge
  } intcStrobes_t;
endpackage

// File: rtl/intc_status.sv
module intc_status
  import intc_pkg::*;
#(
  parameter int              NSRC         = 8,
  parameter logic [NSRC-1:0] RSV_MASK     = '0,
  parameter logic [NSRC-1:0] NODELAY_MASK = '0,
  parameter logic [NSRC-1:0] RESET_MASK   = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] postReq,
  input  logic            clrWr,
  input  logic [NSRC-1:0] clrData,
  input  logic            maskWr,
  input  logic [NSRC-1:0] maskData,
  input  logic            enWr,
  input  logic            enData,
  input  logic            rxBufEmpty,
  input  logic            txBufFull,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            en,
  output logic            reqErr,
  output intcStrobes_t    strobes
);
  logic            rxArmed, txArmed;
  logic            rsvPost, rsvClr, postOk, clrOk;
  logic [NSRC-1:0] postEff, clrEff, statusNext, maskNext, effNext, trig;
  logic            enNext, rxTake, txTake;

  always_comb begin
    rsvPost    = |(postReq & RSV_MASK);
    rsvClr     = clrWr & (|(clrData & RSV_MASK));
    postOk     = (|postReq) & ~rsvPost;
    clrOk      = clrWr & ~rsvClr;
    postEff    = postOk ? postReq : '0;
    clrEff     = clrOk ? clrData : '0;
    statusNext = (status & ~clrEff) | postEff;
    maskNext   = maskWr ? maskData : mask;
    enNext     = enWr ? enData : en;
    effNext    = statusNext & maskNext;
    rxTake     = postEff[SRC_RX_HIGH] & maskNext[SRC_RX_HIGH] & rxArmed;
    txTake     = postEff[SRC_TX_LOW] & maskNext[SRC_TX_LOW] & txArmed;
    trig       = effNext;
    trig[SRC_RX_HIGH] = rxTake;
    trig[SRC_TX_LOW]  = txTake;
    strobes.post    = postOk & (|trig);
    strobes.noDelay = |(trig & NODELAY_MASK);
    strobes.kick    = (|effNext) & enNext &
                      (~en | (maskWr & (maskData != mask)));
    strobes.enNext  = enNext;
    strobes.effZero = ~(|effNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= '0;
      mask    <= RESET_MASK;
      en      <= 1'b0;
      reqErr  <= 1'b0;
      rxArmed <= 1'b1;
      txArmed <= 1'b1;
    end else begin
      status  <= statusNext;
      mask    <= maskNext;
      en      <= enNext;
      reqErr  <= rsvPost | rsvClr;
      rxArmed <= rxBufEmpty | (rxArmed & ~rxTake);
      txArmed <= txBufFull | (txArmed & ~txTake);
    end
  end
endmodule

// File: rtl/intc_sched.sv
module intc_sched
  import intc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] dlyCycles,
  input  intcStrobes_t     strobes,
  output logic             irq
);
  localparam logic [DLY_W:0] ONE = {{DLY_W{1'b0}}, 1'b1};

  logic             schedValid, schedNext, fireNow, keepOld;
  logic [DLY_W-1:0] cnt, cntNext;

  always_comb begin
    fireNow   = 1'b0;
    schedNext = schedValid;
    cntNext   = cnt;
    keepOld   = schedValid & (({1'b0, dlyCycles} + ONE) >= {1'b0, cnt});
    if (schedValid) begin
      if (cnt <= 1) begin
        fireNow   = 1'b1;
        schedNext = 1'b0;
      end else begin
        cntNext = cnt - 1'b1;
      end
    end
    if (strobes.post && strobes.enNext) begin
      if (strobes.noDelay || dlyCycles == '0) begin
        fireNow = 1'b1;
      end else if (!keepOld) begin
        schedNext = 1'b1;
        cntNext   = dlyCycles;
      end
    end
    if (strobes.kick) fireNow = 1'b1;
    if (fireNow) schedNext = 1'b0;
    if (!strobes.enNext || strobes.effZero) begin
      fireNow   = 1'b0;
      schedNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      schedValid <= 1'b0;
      cnt        <= '0;
      irq        <= 1'b0;
    end else begin
      schedValid <= schedNext;
      cnt        <= cntNext;
      irq        <= ~strobes.effZero & (irq | fireNow);
    end
  end
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit
  import intc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  postReq,
  input  logic             clrWr,
  input  logic [NSRC-1:0]  clrData,
  input  logic             maskWr,
  input  logic [NSRC-1:0]  maskData,
  input  logic             enWr,
  input  logic             enData,
  input  logic [DLY_W-1:0] dlyCycles,
  input  logic             rxBufEmpty,
  input  logic             txBufFull,
  output logic [NSRC-1:0]  statusOut,
  output logic [NSRC-1:0]  maskOut,
  output logic             enOut,
  output logic             irqOut,
  output logic             reqErr
);
  localparam logic [NSRC-1:0] RSV_MASK     = NSRC'(1) << SRC_RSV;
  localparam logic [NSRC-1:0] NODELAY_MASK = NSRC'(1) << SRC_TX_FULL;
  localparam logic [NSRC-1:0] RESET_MASK   = (NSRC'(1) << SRC_RX_DMA) |
                                             (NSRC'(1) << SRC_RX_HIGH) |
                                             (NSRC'(1) << SRC_TX_LOW);

  intcStrobes_t strobes;

  intc_status #(
    .NSRC(NSRC), .RSV_MASK(RSV_MASK),
    .NODELAY_MASK(NODELAY_MASK), .RESET_MASK(RESET_MASK)
  ) u_status (
    .clk(clk), .rstN(rstN), .postReq(postReq), .clrWr(clrWr),
    .clrData(clrData), .maskWr(maskWr), .maskData(maskData),
    .enWr(enWr), .enData(enData), .rxBufEmpty(rxBufEmpty),
    .txBufFull(txBufFull), .status(statusOut), .mask(maskOut),
    .en(enOut), .reqErr(reqErr), .strobes(strobes)
  );

  intc_sched #(.DLY_W(DLY_W)) u_sched (
    .clk(clk), .rstN(rstN), .dlyCycles(dlyCycles),
    .strobes(strobes), .irq(irqOut)
  );
endmodule

// File: rtl/irq_coalesce_unit_chk.sv
module irq_coalesce_unit_chk #(
  parameter int              NSRC     = 8,
  parameter logic [NSRC-1:0] RSV_MASK = '0
) (
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] postReq,
  input logic            clrWr,
  input logic [NSRC-1:0] statusOut,
  input logic [NSRC-1:0] maskOut,
  input logic            enOut,
  input logic            irqOut,
  input logic            reqErr
);
  // R4
  irq_needs_eff_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|(statusOut & maskOut)));

  // R3
  rsv_post_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(postReq & RSV_MASK)) |=> reqErr);

  // R3
  rsv_post_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|(postReq & RSV_MASK)) && !clrWr) |=> (statusOut == $past(statusOut)));

  // R2
  post_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|postReq) && !(|(postReq & RSV_MASK)) && !clrWr)
      |=> ((statusOut & $past(postReq)) == $past(postReq)));

  // R11
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> enOut);

  // R3
  rsv_never_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & RSV_MASK) == '0);
endmodule

bind irq_coalesce_unit irq_coalesce_unit_chk #(
  .NSRC(NSRC), .RSV_MASK(RSV_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .postReq(postReq), .clrWr(clrWr),
  .statusOut(statusOut), .maskOut(maskOut), .enOut(enOut),
  .irqOut(irqOut), .reqErr(reqErr)
);

// File: tb/test_irq_coalesce_unit.sv
`timescale 1ns/1ps
module test_irq_coalesce_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] postReq = '0, clrData = '0, maskData = '0;
  logic       clrWr = 1'b0, maskWr = 1'b0, enWr = 1'b0, enData = 1'b0;
  logic [7:0] dlyCycles = 8'd3;
  logic       rxBufEmpty = 1'b0, txBufFull = 1'b0;
  logic [7:0] statusOut, maskOut;
  logic       enOut, irqOut, reqErr;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  irq_coalesce_unit i_irq_coalesce_unit (
    .clk(clk), .rstN(rstN), .postReq(postReq), .clrWr(clrWr),
    .clrData(clrData), .maskWr(maskWr), .maskData(maskData),
    .enWr(enWr), .enData(enData), .dlyCycles(dlyCycles),
    .rxBufEmpty(rxBufEmpty), .txBufFull(txBufFull),
    .statusOut(statusOut), .maskOut(maskOut), .enOut(enOut),
    .irqOut(irqOut), .reqErr(reqErr)
  );

  task automatic step();
    @(posedge clk);
    #5;
    postReq = '0; clrWr = 1'b0; maskWr = 1'b0; enWr = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; steps(2); rstN = 1'b1; step();
  endtask

  task automatic setEn(input logic v);
    enWr = 1'b1; enData = v; step();
  endtask

  task automatic setMask(input logic [7:0] m);
    maskWr = 1'b1; maskData = m; step();
  endtask

  task automatic post(input logic [7:0] p);
    postReq = p; step();
  endtask

  task automatic clr(input logic [7:0] c);
    clrWr = 1'b1; clrData = c; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 status", statusOut, 0);
    check("R1 mask", maskOut, 8'h25);
    check("R1 enable", enOut, 0);
    check("R1 irq", irqOut, 0);

    // Sweep every single source bit with the mask open, delay 3
    for (int b = 0; b < 8; b++) begin
      doReset();
      dlyCycles = 8'd3;
      setEn(1'b1);
      setMask(8'hFF);
      post(8'(1 << b));
      if (b == 7) begin
        check("R3 rsv post status", statusOut, 0);
        check("R3 rsv post err", reqErr, 1);
      end else begin
        check("R2 post status", statusOut, 32'(1 << b));
      end
      for (int k = 0; k <= 4; k++) begin
        if (k > 0) step();
        if (b == 7)      check("R3 rsv irq", irqOut, 0);
        else if (b == 6) check("R6 immediate irq", irqOut, 1);
        else             check("R5 delayed irq", irqOut, (k >= 3) ? 1 : 0);
      end
      if (b != 7) begin
        clr(8'(1 << b));
        check("R4 clear irq", irqOut, 0);
        check("R2 clear status", statusOut, 0);
      end
    end

    // R5 zero delay delivers at the accepting edge
    doReset(); dlyCycles = 8'd0; setEn(1'b1);
    post(8'h01);
    check("R5 zero delay", irqOut, 1);

    // R2 same-cycle post and clear; OR of posts; R3 reserved clear
    doReset(); setMask(8'h00);
    post(8'h01);
    post(8'h08);
    check("R2 or status", statusOut, 8'h09);
    clrWr = 1'b1; clrData = 8'h01; postReq = 8'h01; step();
    check("R2 post wins", statusOut, 8'h09);
    clr(8'h81);
    check("R3 rsv clear status", statusOut, 8'h09);
    check("R3 rsv clear err", reqErr, 1);
    step();
    check("R3 err drops", reqErr, 0);

    // R8 receive-high hysteresis
    doReset(); dlyCycles = 8'd3; setEn(1'b1);
    post(8'h04); steps(3);
    check("R8 armed fires", irqOut, 1);
    clr(8'h04);
    post(8'h04); steps(4);
    check("R8 disarmed quiet", irqOut, 0);
    check("R8 status set", statusOut, 8'h04);
    clr(8'h04);
    rxBufEmpty = 1'b1; step(); rxBufEmpty = 1'b0;
    post(8'h04); steps(3);
    check("R8 rearmed fires", irqOut, 1);

    // R9 transmit-low hysteresis
    doReset(); dlyCycles = 8'd3; setEn(1'b1);
    post(8'h20); steps(3);
    check("R9 armed fires", irqOut, 1);
    clr(8'h20);
    post(8'h20); steps(4);
    check("R9 disarmed quiet", irqOut, 0);
    clr(8'h20);
    txBufFull = 1'b1; step(); txBufFull = 1'b0;
    post(8'h20); steps(3);
    check("R9 rearmed fires", irqOut, 1);

    // R7 merge keeps the earlier delivery
    doReset(); dlyCycles = 8'd6; setEn(1'b1); setMask(8'hFF);
    post(8'h01);         // edge t0
    step();              // t0+1
    post(8'h08);         // t0+2
    steps(3);            // t0+5
    check("R7 before merged", irqOut, 0);
    step();              // t0+6
    check("R7 merged fires", irqOut, 1);

    // R6 immediate class overrides a waiting delivery
    doReset(); dlyCycles = 8'd6; setEn(1'b1); setMask(8'hFF);
    post(8'h01);
    post(8'h40);
    check("R6 override", irqOut, 1);

    // R10 mask write delivers immediately
    doReset(); dlyCycles = 8'd3; setEn(1'b1); setMask(8'h00);
    post(8'h01); steps(4);
    check("R10 masked quiet", irqOut, 0);
    setMask(8'h01);
    check("R10 mask fires", irqOut, 1);

    // R11 disabled posts stay quiet, enabling fires
    doReset(); dlyCycles = 8'd3;
    post(8'h01); steps(4);
    check("R11 disabled quiet", irqOut, 0);
    setEn(1'b1);
    check("R11 enable fires", irqOut, 1);

    // R12 cancel by disable
    doReset(); dlyCycles = 8'd4; setEn(1'b1);
    post(8'h01);
    setEn(1'b0); steps(5);
    check("R12 disable cancels", irqOut, 0);
    // R12 cancel by clear, then a fresh post still works
    doReset(); dlyCycles = 8'd4; setEn(1'b1);
    post(8'h01);
    clr(8'h01); steps(5);
    check("R12 clear cancels", irqOut, 0);
    post(8'h01); steps(4);
    check("R12 fresh post fires", irqOut, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule